// File: doc/BRIEF.md
# Crosspoint Matrix Configuration Controller

This block holds the switch setting for a 32-output by 32-input analog crosspoint matrix. Each output owns a 6-bit word: the low five bits name the input it listens to, and the top bit turns the output on. The 32 words sit in two ranks. Words are written into a staging rank. A commit strobe then copies the whole staging rank into an active rank, which drives the matrix. Until that strobe arrives, staged changes do not reach the switches.

The staging rank can be written in two ways. In serial mode it acts as a single 192-bit shift chain. Its far end is brought out so that several controllers can be chained from one data line. In parallel mode one output's word is written at a time, picked by a 5-bit address. Each active word feeds a 5-to-32 one-hot decoder gated by its enable bit. Together the decoders produce 1024 crosspoint enables and 32 output-enable lines. An asynchronous active-low reset turns every output off and leaves the staged setting in place.

The staging path is chosen every clock by a three-way operation code, with no further state: `OP_SHIFT` when `ser_sel` is high, `OP_WRITE` when `ser_sel` is low and `wr_en` is high, and `OP_HOLD` otherwise. There is no transition logic between these three cases.

Top module: `xp_matrix_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `out_en` and `xp_en` is 0 within the same cycle. Reset does not change the staging rank, so a commit after reset restores the staged setting.
- R2: With `ser_sel` high, the chain shifts one place on each rising clock edge and takes `chain_in` in at the near end. Output k owns chain bits [6k+5:6k]. After 192 shifts, the first bit shifted in sits in output 31's bit 5.
- R3: In serial mode, `chain_out` shows the bit at the far end of the chain (output 31's bit 5). A bit presented on `chain_in` therefore appears on `chain_out` after exactly 192 shift clocks.
- R4: With `ser_sel` low and `wr_en` high, a clock edge loads `wr_word` into the slot of output `wr_addr` only. All other slots keep their values.
- R5: With `ser_sel` low, the chain does not shift and `chain_out` holds its value, even when output 31's slot is written.
- R6: With `ser_sel` low and `wr_en` low, the staging rank is unchanged.
- R7: While `upd_n` is high, the active rank, and so `out_en` and `xp_en`, do not change, whatever the staging rank does.
- R8: A clock edge with `upd_n` low copies all 192 staged bits into the active rank. The copy uses the staging contents from before that same edge. Holding `upd_n` low repeats the copy on every edge.
- R9: For an enabled output k with input field s (word bits [4:0]), `out_en[k]` is 1 and `xp_en[32k+s]` is 1. The other 31 bits of that row are 0.
- R10: For an output whose word bit 5 is 0, `out_en[k]` is 0 and `xp_en[32k+31:32k]` is all zeros.
- R11: A low `upd_n` has no effect while `rst_n` is low. Outputs stay off after reset is released until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for shifting, word writes and commits |
| rst_n | input | 1 | Asynchronous active-low reset; turns all outputs off |
| ser_sel | input | 1 | 1 = serial shifting, 0 = addressed word writes |
| chain_in | input | 1 | Serial data into the near end of the chain |
| chain_out | output | 1 | Far end of the chain, for daisy chaining |
| wr_en | input | 1 | Word write strobe, used in parallel mode |
| wr_addr | input | 5 | Output index written in parallel mode |
| wr_word | input | 6 | Word written: bit 5 enable, bits 4:0 input index |
| upd_n | input | 1 | Active-low synchronous commit strobe |
| xp_en | output | 1024 | Crosspoint enables, bit 32k+i joins input i to output k |
| out_en | output | 32 | Output buffer enables |

## Verification
A wrong bit in the staging rank stays hidden until a commit. After the commit it appears as a misplaced or missing crosspoint one cycle later, or, if the bit is in the chain, as a wrong `chain_out` value up to 192 shifts later. The bench therefore commits after every kind of load and compares the whole 1024-bit enable field. It also watches `chain_out` while a second pattern pushes the first one out. A wrong active-rank bit, or an enable that reset fails to clear, shows on `out_en` and `xp_en` in the cycle itself.

// File: rtl/xp_pkg.sv
package xp_pkg;

    localparam int XP_OUTS = 32;
    localparam int XP_INS  = 32;

    // operation applied to the staging rank on the next clock edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_WRITE = 2'd2
    } stage_op_e;

endpackage

// File: rtl/xp_stage_rank.sv
module xp_stage_rank
    import xp_pkg::*;
#(
    parameter int N_OUT  = XP_OUTS,
    parameter int WORD_W = 6,
    localparam int ADDR_W  = $clog2(N_OUT),
    localparam int CHAIN_W = N_OUT * WORD_W
) (
    input  logic               clk,
    input  stage_op_e          op,
    input  logic               chain_in,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_word,
    output logic [CHAIN_W-1:0] stage,
    output logic               chain_out
);

    logic [CHAIN_W-1:0] stage_q;
    logic               tail_q;

    // staging rank: shift, addressed write or hold
    always_ff @(posedge clk) begin
        unique case (op)
            OP_SHIFT: stage_q <= {stage_q[CHAIN_W-2:0], chain_in};
            OP_WRITE: begin
                if (int'(wr_addr) < N_OUT)
                    stage_q[int'(wr_addr)*WORD_W +: WORD_W] <= wr_word;
            end
            default: ;
        endcase
    end

    // far-end copy that moves only while shifting
    always_ff @(posedge clk) begin
        if (op == OP_SHIFT)
            tail_q <= stage_q[CHAIN_W-2];
    end

    assign stage     = stage_q;
    assign chain_out = tail_q;

endmodule

// File: rtl/xp_active_rank.sv
module xp_active_rank #(
    parameter int N_OUT  = 32,
    parameter int SEL_W  = 5,
    localparam int WORD_W  = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CHAIN_W-1:0] stage,
    output logic [CHAIN_W-1:0] act
);

    logic [N_OUT-1:0]            en_q;
    logic [N_OUT-1:0][SEL_W-1:0] sel_q;

    for (genvar k = 0; k < N_OUT; k++) begin : g_slot
        // enable bit: cleared asynchronously
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_q[k] <= 1'b0;
            else if (load)
                en_q[k] <= stage[k*WORD_W + SEL_W];
        end

        // input index: no reset, commit blocked during reset
        always_ff @(posedge clk) begin
            if (rst_n && load)
                sel_q[k] <= stage[k*WORD_W +: SEL_W];
        end

        assign act[k*WORD_W +: WORD_W] = {en_q[k], sel_q[k]};
    end

endmodule

// File: rtl/xp_row_decoder.sv
module xp_row_decoder #(
    parameter int N_IN  = 32,
    parameter int SEL_W = 5
) (
    input  logic [SEL_W:0]    word,
    output logic [N_IN-1:0]   row,
    output logic              oe
);

    always_comb begin
        for (int i = 0; i < N_IN; i++)
            row[i] = word[SEL_W] && (word[SEL_W-1:0] == SEL_W'(i));
    end

    assign oe = word[SEL_W];

endmodule

// File: rtl/xp_matrix_ctrl.sv
module xp_matrix_ctrl
    import xp_pkg::*;
#(
    parameter int N_OUT = XP_OUTS,
    parameter int N_IN  = XP_INS,
    localparam int SEL_W   = $clog2(N_IN),
    localparam int WORD_W  = SEL_W + 1,
    localparam int ADDR_W  = $clog2(N_OUT),
    localparam int CHAIN_W = N_OUT * WORD_W,
    localparam int XP_W    = N_OUT * N_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel,
    input  logic              chain_in,
    output logic              chain_out,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              upd_n,
    output logic [XP_W-1:0]   xp_en,
    output logic [N_OUT-1:0]  out_en
);

    stage_op_e          op;
    logic [CHAIN_W-1:0] stage_w;
    logic [CHAIN_W-1:0] act_w;

    // operation select
    always_comb begin
        unique case ({ser_sel, wr_en})
            2'b10, 2'b11: op = OP_SHIFT;
            2'b01:        op = OP_WRITE;
            default:      op = OP_HOLD;
        endcase
    end

    xp_stage_rank #(
        .N_OUT  (N_OUT),
        .WORD_W (WORD_W)
    ) stage_i (
        .clk       (clk),
        .op        (op),
        .chain_in  (chain_in),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word),
        .stage     (stage_w),
        .chain_out (chain_out)
    );

    xp_active_rank #(
        .N_OUT (N_OUT),
        .SEL_W (SEL_W)
    ) active_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!upd_n),
        .stage (stage_w),
        .act   (act_w)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_dec
        xp_row_decoder #(
            .N_IN  (N_IN),
            .SEL_W (SEL_W)
        ) dec_i (
            .word (act_w[k*WORD_W +: WORD_W]),
            .row  (xp_en[k*N_IN +: N_IN]),
            .oe   (out_en[k])
        );
    end

endmodule

// File: rtl/xp_matrix_ctrl_chk.sv
module xp_matrix_ctrl_chk #(
    parameter int N_OUT   = 32,
    parameter int CHAIN_W = 192,
    parameter int XP_W    = 1024
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_sel,
    input logic               wr_en,
    input logic               upd_n,
    input logic               chain_in,
    input logic               chain_out,
    input logic [CHAIN_W-1:0] stage_w,
    input logic [CHAIN_W-1:0] act_w,
    input logic [N_OUT-1:0]   out_en,
    input logic [XP_W-1:0]    xp_en
);

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel |=> stage_w == {$past(stage_w[CHAIN_W-2:0]), $past(chain_in)});

    // R5
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_sel |=> $stable(chain_out));

    // R6
    idle_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_sel && !wr_en) |=> $stable(stage_w));

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_n |=> $stable(act_w));

    // R8
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_n |=> act_w == $past(stage_w));

    // R9
    row_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(xp_en) == $countones(out_en));

endmodule

bind xp_matrix_ctrl xp_matrix_ctrl_chk #(
    .N_OUT   (N_OUT),
    .CHAIN_W (CHAIN_W),
    .XP_W    (XP_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_sel   (ser_sel),
    .wr_en     (wr_en),
    .upd_n     (upd_n),
    .chain_in  (chain_in),
    .chain_out (chain_out),
    .stage_w   (stage_w),
    .act_w     (act_w),
    .out_en    (out_en),
    .xp_en     (xp_en)
);

// File: tb/xp_matrix_ctrl_tb_top.sv
`timescale 1ns/1ps
module xp_matrix_ctrl_tb_top;

    localparam int NO = 32;
    localparam int NI = 32;
    localparam int W  = 6;
    localparam int CW = NO * W;
    localparam int XW = NO * NI;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_sel = 1'b0;
    logic          chain_in = 1'b0;
    logic          chain_out;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [5:0]    wr_word = '0;
    logic          upd_n = 1'b1;
    logic [XW-1:0] xp_en;
    logic [NO-1:0] out_en;

    always #10 clk = ~clk;

    xp_matrix_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_sel   (ser_sel),
        .chain_in  (chain_in),
        .chain_out (chain_out),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word),
        .upd_n     (upd_n),
        .xp_en     (xp_en),
        .out_en    (out_en)
    );

    typedef struct {
        string         req;
        logic [NO-1:0] oe;
        logic [XW-1:0] xp;
        bit            so_chk;
        logic          so;
    } item_t;

    item_t    sb_q[$];
    int       n_chk = 0;
    int       n_err = 0;

    bit [CW-1:0] m_stage = '0;
    bit [CW-1:0] m_act   = '0;
    bit          m_so    = 1'b0;
    bit          so_known = 1'b0;

    function automatic logic [5:0] pat(int p, int k);
        if (p == 1) return {(k % 5) != 2, 5'((k * 7 + 3) % 32)};
        return {(k % 3) != 0, 5'(31 - k)};
    endfunction

    task automatic push_exp(string req);
        item_t it;
        it.req = req;
        it.oe  = '0;
        it.xp  = '0;
        for (int k = 0; k < NO; k++) begin
            if (m_act[k*W+5]) begin
                it.oe[k] = 1'b1;
                it.xp[k*NI + int'(m_act[k*W +: 5])] = 1'b1;
            end
        end
        it.so_chk = so_known;
        it.so     = m_so;
        sb_q.push_back(it);
    endtask

    // one clock of stimulus, model update, expectation pushed
    task automatic cyc(bit ser, bit din, bit we, logic [4:0] a,
                       logic [5:0] w, bit upd, string req);
        @(negedge clk);
        ser_sel = ser; chain_in = din; wr_en = we;
        wr_addr = a; wr_word = w; upd_n = upd;
        @(posedge clk);
        #1;
        if (!upd) m_act = m_stage;
        if (ser) begin
            m_so    = m_stage[CW-2];
            m_stage = {m_stage[CW-2:0], din};
        end else if (we) begin
            m_stage[int'(a)*W +: W] = w;
        end
        push_exp(req);
    endtask

    task automatic load_serial(int p, string req);
        for (int k = NO - 1; k >= 0; k--) begin
            for (int b = W - 1; b >= 0; b--) begin
                logic [5:0] w = pat(p, k);
                cyc(1'b1, w[b], 1'b0, '0, '0, 1'b1, req);
            end
        end
    endtask

    task automatic reset_pulse(bit upd_during);
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        upd_n = upd_during ? 1'b0 : 1'b1;
        for (int k = 0; k < NO; k++) m_act[k*W+5] = 1'b0;
        push_exp("R1");
        @(posedge clk);
        #2;
        upd_n = 1'b1;
        rst_n = 1'b1;
        push_exp("R11");
    endtask

    // monitor: compare one expectation per falling edge
    always @(negedge clk) begin
        item_t it;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_chk++;
            if (out_en !== it.oe || xp_en !== it.xp) begin
                n_err++;
                $display("FAIL %s out_en act=%h exp=%h xp_en act=%h exp=%h",
                         it.req, out_en, it.oe, xp_en, it.xp);
            end
            if (it.so_chk) begin
                n_chk++;
                if (chain_out !== it.so) begin
                    n_err++;
                    $display("FAIL %s chain_out act=%b exp=%b",
                             it.req, chain_out, it.so);
                end
            end
        end
    end

    initial begin
        #3000000;
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        push_exp("R1");
        @(posedge clk);
        #2;
        rst_n = 1'b1;

        // fill chain with zeros so the far end is known
        for (int i = 0; i < CW; i++)
            cyc(1'b1, 1'b0, 1'b0, '0, '0, 1'b1, "R2");
        so_known = 1'b1;

        // R2/R3/R7: serial load, active rank must not move
        load_serial(1, "R7");
        // R8/R9/R10: commit and decode
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R8");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, "R9");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, "R10");

        // R3: second pattern pushes the first out of the far end
        load_serial(2, "R3");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R2");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, "R9");

        // R4/R5: addressed writes, slot 31 written while far end holds
        cyc(1'b0, 1'b1, 1'b1, 5'd31, 6'b1_00000, 1'b1, "R5");
        cyc(1'b0, 1'b0, 1'b1, 5'd0,  6'b1_11111, 1'b1, "R4");
        cyc(1'b0, 1'b0, 1'b1, 5'd5,  6'b0_01010, 1'b1, "R4");
        cyc(1'b0, 1'b0, 1'b1, 5'd17, 6'b1_00111, 1'b1, "R7");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R4");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, "R10");

        // R6: strobe low, word on the bus ignored
        cyc(1'b0, 1'b1, 1'b0, 5'd9, 6'b1_10101, 1'b1, "R6");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R6");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, "R6");

        // R8: commit held low while writing, follows each edge
        cyc(1'b0, 1'b0, 1'b1, 5'd2,  6'b1_00100, 1'b0, "R8");
        cyc(1'b0, 1'b0, 1'b1, 5'd2,  6'b1_11000, 1'b0, "R8");
        cyc(1'b0, 1'b0, 1'b1, 5'd30, 6'b0_00001, 1'b0, "R8");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, "R8");

        // R1/R11: reset with commit attempts, staging kept
        reset_pulse(1'b1);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, "R11");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R1");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, "R1");
        reset_pulse(1'b0);

        // drain the scoreboard
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule